// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one framed clock lane. The word changes once per pixel clock period. A bit clock running at seven times the pixel rate is a primary input, with a known phase. The block samples the pixel clock in the bit-clock domain and picks up a word on the rising or the falling pixel edge, as set by a static select pin. It scatters the 28 bits over the four lanes according to a fixed, interleaved assignment and shifts each lane out one bit per bit-clock cycle, most significant position first.

A free-running modulo-7 slot counter chooses one load slot in every seven bit cycles. At that slot the most recently captured word moves into all four lane shift registers at once. The clock lane is loaded from a constant frame pattern at the same moment, so it always marks the frame boundary of the data it travels with. An active-low shutdown input forces every output to 0, drops the output-enable flag and clears all state. Transmission then resumes at the first load slot after a new word has been captured.

Top module: `disp_ser7_tx`

## Requirements
- R1: Each data lane sends exactly 7 bits per frame, one bit per bit-clock cycle, and a new frame starts every 7 bit-clock cycles, so the 28 input bits leave in one pixel period.
- R2: Lane 0 (`ser_data[0]`) carries input bits 0, 1, 2, 3, 4, 6, 7 at lane positions 0 to 6, with position 0 the least significant.
- R3: Lane 1 carries input bits 8, 9, 12, 13, 14, 15, 18 at positions 0 to 6, and lane 2 carries input bits 19, 20, 21, 22, 24, 25, 26 at positions 0 to 6.
- R4: Lane 3 carries input bits 27, 5, 10, 11, 16, 17, 23 at positions 0 to 6.
- R5: Within a frame, slot 0 (the first bit sent) carries lane position 6 and slot 6 carries position 0.
- R6: With `rise_sel` = 1 the word captured is the one present at the first bit-clock edge that sees `pix_clk` high after being low. With `rise_sel` = 0 it is the one present when `pix_clk` is first seen low after being high. A word present only around the opposite pixel edge is never sent.
- R7: While `ser_oe` is high, the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every frame, in the same cycles as the data bits.
- R8: All four lanes of a frame come from one captured word. When the pixel period equals 7 bit periods, every captured word is sent exactly once, in capture order.
- R9: While `shut_n` is low, `ser_data` and `ser_clk` are 0 and `ser_oe` is 0, from the cycle it falls onward, and all internal state is cleared.
- R10: After `shut_n` (or `rst_n`) is released, `ser_oe` stays 0 and the outputs stay 0 until a word has been captured. The first frame then starts at the next load slot and carries that word.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Serial bit clock, 7x pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| shut_n | input | 1 | Active-low shutdown; clears state and silences outputs |
| pix_clk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| rise_sel | input | 1 | 1 captures on the rising pixel edge, 0 on the falling edge |
| pix_data | input | 28 | Parallel pixel word |
| ser_data | output | 4 | Serial data lanes, bit n is lane n |
| ser_clk | output | 1 | Framed clock lane |
| ser_oe | output | 1 | High while frames are being sent |

## Verification
Walking-one words expose any lane mapping or bit-order slip, because a single misplaced bit shows up as a mismatch on exactly one lane. In every pixel period the bench first drives the inverted word and then switches to the true word just before the selected capture edge. A design that captured on the wrong edge would therefore send the inverted decoy. Shutdown is applied in the middle of a frame. Afterwards the bench holds the pixel clock idle: a design that kept the old captured word would raise `ser_oe` and replay stale data. It would also duplicate or drop a frame at the start of the next scoreboard run. The clock-lane pattern is checked on every frame, so a clock lane that drifted against the load slot shows up as a failure.

// File: rtl/disp_ser7_pkg.sv
`timescale 1ns/1ps
package disp_ser7_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned SLOTS  = 7;
  localparam int unsigned WORD_W = LANES * SLOTS;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef logic [SLOTS-1:0] frame_t;

  // Frame marker for the clock lane, bit SLOTS-1 goes out first.
  localparam frame_t FRAME_PAT = 7'b1100011;

  // Source bit of the parallel word for [lane][position], position 0 = LSB.
  localparam int unsigned LANE_MAP [LANES][SLOTS] = '{
    '{ 0,  1,  2,  3,  4,  6,  7},
    '{ 8,  9, 12, 13, 14, 15, 18},
    '{19, 20, 21, 22, 24, 25, 26},
    '{27,  5, 10, 11, 16, 17, 23}
  };

endpackage

// File: rtl/disp_ser7_rst_sync.sv
`timescale 1ns/1ps
module disp_ser7_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/disp_ser7_capture.sv
`timescale 1ns/1ps
module disp_ser7_capture #(
  parameter int unsigned W    = 28,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_clk,
  input  logic         rise_sel,
  input  logic [W-1:0] pix_data,
  output logic [W-1:0] word_q,
  output logic         word_vld
);

  // Pixel clock sampler: SYNC stages plus one history stage for the edge.
  logic [SYNC:0]  pclk_q;
  logic [SYNC:0]  pclk_d;
  // Data delayed to line up with pclk_q[SYNC-1].
  logic [W-1:0]   dpipe_q [SYNC];
  logic [W-1:0]   dpipe_d [SYNC];
  logic           edge_hit;
  logic [W-1:0]   word_d;
  logic           vld_d;

  always_comb begin
    pclk_d     = {pclk_q[SYNC-1:0], pix_clk};
    dpipe_d[0] = pix_data;
    for (int s = 1; s < SYNC; s++) begin
      dpipe_d[s] = dpipe_q[s-1];
    end
  end

  always_comb begin
    if (rise_sel) begin
      edge_hit = pclk_q[SYNC-1] & ~pclk_q[SYNC];
    end else begin
      edge_hit = ~pclk_q[SYNC-1] & pclk_q[SYNC];
    end
    word_d = edge_hit ? dpipe_q[SYNC-1] : word_q;
    vld_d  = word_vld | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= '0;
    end else begin
      pclk_q <= pclk_d;
    end
  end

  for (genvar s = 0; s < SYNC; s++) begin : g_dpipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dpipe_q[s] <= '0;
      end else begin
        dpipe_q[s] <= dpipe_d[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      word_q   <= word_d;
      word_vld <= vld_d;
    end
  end

endmodule

// File: rtl/disp_ser7_slot_ctr.sv
`timescale 1ns/1ps
module disp_ser7_slot_ctr #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned CW   = $clog2(SLOTS)
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_stb
);

  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    load_stb = (cnt_q == LAST);
    cnt_d    = load_stb ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/disp_ser7_lane.sv
`timescale 1ns/1ps
module disp_ser7_lane #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] par,
  output logic         ser
);

  logic [N-1:0] sr_q;
  logic [N-1:0] sr_d;

  always_comb begin
    if (load_en) begin
      sr_d = par;
    end else begin
      sr_d = {sr_q[N-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign ser = sr_q[N-1];

endmodule

// File: rtl/disp_ser7_tx.sv
`timescale 1ns/1ps
module disp_ser7_tx
  import disp_ser7_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              shut_n,
  input  logic              pix_clk,
  input  logic              rise_sel,
  input  logic [WORD_W-1:0] pix_data,
  output logic [LANES-1:0]  ser_data,
  output logic              ser_clk,
  output logic              ser_oe
);

  logic              arst_n;
  logic              core_rst_n;
  logic [WORD_W-1:0] cap_word;
  logic              cap_vld;
  logic              load_stb;
  frame_t            lane_word [LANES];
  logic [LANES-1:0]  lane_ser;
  logic              clk_ser;
  logic              oe_q;
  logic              oe_d;

  assign arst_n = rst_n & shut_n;

  disp_ser7_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk_bit),
    .arst_n (arst_n),
    .srst_n (core_rst_n)
  );

  disp_ser7_capture #(.W(WORD_W), .SYNC(SYNC_STAGES)) u_cap (
    .clk      (clk_bit),
    .rst_n    (core_rst_n),
    .pix_clk  (pix_clk),
    .rise_sel (rise_sel),
    .pix_data (pix_data),
    .word_q   (cap_word),
    .word_vld (cap_vld)
  );

  disp_ser7_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk      (clk_bit),
    .rst_n    (core_rst_n),
    .load_stb (load_stb)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar p = 0; p < SLOTS; p++) begin : g_pos
      assign lane_word[l][p] = cap_word[LANE_MAP[l][p]];
    end

    disp_ser7_lane #(.N(SLOTS)) u_lane (
      .clk     (clk_bit),
      .rst_n   (core_rst_n),
      .load_en (load_stb),
      .par     (lane_word[l]),
      .ser     (lane_ser[l])
    );
  end

  disp_ser7_lane #(.N(SLOTS)) u_clk_lane (
    .clk     (clk_bit),
    .rst_n   (core_rst_n),
    .load_en (load_stb),
    .par     (FRAME_PAT),
    .ser     (clk_ser)
  );

  always_comb begin
    oe_d = oe_q | (load_stb & cap_vld);
  end

  always_ff @(posedge clk_bit or negedge core_rst_n) begin
    if (!core_rst_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
    end
  end

  assign ser_data = lane_ser & {LANES{oe_q}};
  assign ser_clk  = clk_ser & oe_q;
  assign ser_oe   = oe_q;

endmodule

// File: rtl/disp_ser7_chk.sv
`timescale 1ns/1ps
module disp_ser7_chk
  import disp_ser7_pkg::*;
(
  input logic             clk_bit,
  input logic             rst_n,
  input logic             shut_n,
  input logic [LANES-1:0] ser_data,
  input logic             ser_clk,
  input logic             ser_oe
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  // Independent slot tracker: 0 in the first cycle of a sending frame.
  logic [SLOT_W-1:0] ph_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (!ser_oe || ph_q == LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  p_idle_quiet_r9: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !ser_oe |-> (ser_data == '0) && !ser_clk);

  p_shutdown_off_r9: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !shut_n |=> !ser_oe);

  p_clk_pattern_r7: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ser_oe |-> ser_clk == FRAME_PAT[LAST - ph_q]);

  p_frame_start_r10: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(ser_oe) |-> shut_n && $past(shut_n));

endmodule

bind disp_ser7_tx disp_ser7_chk u_chk (
  .clk_bit  (clk_bit),
  .rst_n    (rst_n),
  .shut_n   (shut_n),
  .ser_data (ser_data),
  .ser_clk  (ser_clk),
  .ser_oe   (ser_oe)
);

// File: tb/disp_ser7_tx_test.sv
`timescale 1ns/1ps
module disp_ser7_tx_test;

  logic        clk_bit = 1'b0;
  logic        rst_n;
  logic        shut_n;
  logic        pix_clk;
  logic        rise_sel;
  logic [27:0] pix_data;
  logic [3:0]  ser_data;
  logic        ser_clk;
  logic        ser_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [27:0] exp_q [$];

  // Lane assignment per requirements R2, R3, R4: [lane][position], position 0 = LSB.
  localparam int TB_MAP [4][7] = '{
    '{ 0,  1,  2,  3,  4,  6,  7},
    '{ 8,  9, 12, 13, 14, 15, 18},
    '{19, 20, 21, 22, 24, 25, 26},
    '{27,  5, 10, 11, 16, 17, 23}
  };

  always #2.5 clk_bit = ~clk_bit;

  disp_ser7_tx uut (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .shut_n   (shut_n),
    .pix_clk  (pix_clk),
    .rise_sel (rise_sel),
    .pix_data (pix_data),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_oe   (ser_oe)
  );

  task automatic check(input bit ok, input string req,
                       input logic [27:0] got, input logic [27:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [6:0] lane_bits(input logic [27:0] w, input int l);
    logic [6:0] r;
    for (int p = 0; p < 7; p++) r[p] = w[TB_MAP[l][p]];
    return r;
  endfunction

  function automatic logic [27:0] gen_word(input int kind, input int i);
    logic [31:0] h;
    case (kind)
      0: return 28'h1 << (i % 28);
      1: case (i % 4)
           0: return 28'hAAAAAAA;
           1: return 28'h5555555;
           2: return 28'hFFFFFFF;
           default: return 28'h0000000;
         endcase
      default: begin
        h = (i + 1) * 32'h9E3779B1;
        h = h ^ (h >> 13);
        return h[27:0];
      end
    endcase
  endfunction

  // Monitor: collects one frame per lane and compares with the scoreboard (R1, R5, R8).
  logic       prev_oe = 1'b0;
  int         mslot   = 0;
  logic [6:0] acc [4];
  logic [6:0] cacc;

  always @(negedge clk_bit) begin
    logic [27:0] w;
    logic [6:0]  e;
    if (ser_oe) begin
      mslot = prev_oe ? ((mslot == 6) ? 0 : mslot + 1) : 0;
      for (int l = 0; l < 4; l++) acc[l][6-mslot] = ser_data[l];
      cacc[6-mslot] = ser_clk;
      if (mslot == 6 && exp_q.size() > 0) begin
        w = exp_q.pop_front();
        for (int l = 0; l < 4; l++) begin
          e = lane_bits(w, l);
          case (l)
            0:       check(acc[l] == e, "R2 lane0", {21'b0, acc[l]}, {21'b0, e});
            3:       check(acc[l] == e, "R4 lane3", {21'b0, acc[l]}, {21'b0, e});
            default: check(acc[l] == e, "R3 lane1/2", {21'b0, acc[l]}, {21'b0, e});
          endcase
        end
        check(cacc == 7'b1100011, "R7 clock lane", {21'b0, cacc}, 28'h63);
      end
    end
    prev_oe = ser_oe;
  end

  // Driver: one word per 7 bit cycles; decoy (inverted) word sits at the ignored edge (R6).
  task automatic send_words(input int n, input int kind, input bit rise);
    logic [27:0] w;
    for (int i = 0; i < n; i++) begin
      w = gen_word(kind, i);
      @(negedge clk_bit);
      pix_clk  = rise ? 1'b0 : 1'b1;
      pix_data = ~w;
      @(negedge clk_bit);
      @(negedge clk_bit);
      pix_data = w;
      @(negedge clk_bit);
      exp_q.push_back(w);
      pix_clk = rise ? 1'b1 : 1'b0;
      repeat (3) @(negedge clk_bit);
    end
  endtask

  task automatic drain();
    int waited = 0;
    while (exp_q.size() > 0 && waited < 60) begin
      @(negedge clk_bit);
      waited++;
    end
    check(exp_q.size() == 0, "R8 every word sent once", 28'(exp_q.size()), 28'h0);
    repeat (3) @(negedge clk_bit);
  endtask

  task automatic quiet_check(input int n, input string req);
    bit ok = 1'b1;
    repeat (n) begin
      @(negedge clk_bit);
      #1;
      if (ser_oe || ser_data != 4'h0 || ser_clk) ok = 1'b0;
    end
    check(ok, req, {23'b0, ser_oe, ser_data}, 28'h0);
  endtask

  task automatic do_shutdown(input bit rise);
    @(negedge clk_bit);
    shut_n = 1'b0;
    #1;
    // R9: outputs silenced as soon as shutdown is applied, mid-frame
    check(!ser_oe && ser_data == 4'h0 && !ser_clk, "R9 immediate",
          {22'b0, ser_oe, ser_clk, ser_data}, 28'h0);
    quiet_check(4, "R9 held");
    pix_clk  = 1'b0;
    rise_sel = rise;
    exp_q.delete();
    @(negedge clk_bit);
    shut_n = 1'b1;
    // R10: no captured word yet, so nothing may be sent
    quiet_check(30, "R10 idle after release");
  endtask

  initial begin
    rst_n    = 1'b0;
    shut_n   = 1'b1;
    pix_clk  = 1'b0;
    rise_sel = 1'b1;
    pix_data = '0;
    repeat (3) @(negedge clk_bit);
    #1;
    check(!ser_oe && ser_data == 4'h0 && !ser_clk, "R11 reset state",
          {22'b0, ser_oe, ser_clk, ser_data}, 28'h0);
    @(negedge clk_bit);
    rst_n = 1'b1;
    quiet_check(20, "R10 idle after reset");

    // Walking one, rising capture: isolates each bit's lane and slot (R2-R5 via monitor)
    send_words(28, 0, 1'b1);
    drain();

    // Falling capture with alternating and solid patterns
    do_shutdown(1'b0);
    send_words(20, 1, 1'b0);
    drain();

    // Scrambled words, rising capture
    do_shutdown(1'b1);
    send_words(40, 2, 1'b1);
    drain();

    // Walking one, falling capture
    do_shutdown(1'b0);
    send_words(28, 0, 1'b0);
    drain();

    do_shutdown(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bit);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule